// File: doc/BRIEF.md
# SPI Slave Command Port with Switchable Three-Wire Data Line

This block lets an external microcontroller reach a register space inside a chip over SPI. Every transaction is framed by the select line: the first byte clocked in after select goes low is taken as a command, and every complete byte after it in the same select window is a data byte for that command. The command's top bit marks a read (1) or a write (0). Its remaining bits carry a register or command code, which is handed to the internal side together with a one-cycle strobe.

For write commands each received data byte is presented with a valid strobe. For read commands the block pulls a byte from a register read port and shifts it out MSB first. It pulls the first byte as the command byte ends and another each time a data byte ends. When select rises after a command, an end-of-transfer strobe marks the last data byte as done.

The serial pins are oversampled in the system clock domain through synchronizers, in SPI mode 0. After reset the port uses separate input and output data lines. One write command code switches it permanently, until the next reset, to a single shared bidirectional data line. On that line the block drives only while it returns read data. Pads are outside the block, so the shared line is seen as an input, an output value and an output enable.

Top module: `spiCmdPort`

## Requirements
- R1: After reset the port is in four-wire mode (threeWire = 0), both output enables are low, and cmdValid, dataValid, xferEnd and rdTake are low.
- R2: The first complete byte received MSB first after ssN falls gives one cmdValid pulse, with cmdRead equal to its bit 7 and cmdCode equal to bits 6:0.
- R3: In a write command (bit 7 = 0) each later complete byte gives one dataValid pulse with dataByte equal to the received byte. A read command gives no dataValid.
- R4: In a read command rdTake pulses once when the command byte ends and once when each data byte ends, and rdData is sampled in that cycle. The data byte k that follows is shifted out MSB first and changes only after SCLK falling edges, so the master samples the byte loaded at the end of byte k-1.
- R5: When ssN rises after a command byte was received, xferEnd pulses once. No xferEnd is produced if no command byte completed.
- R6: If ssN rises in the middle of a byte, the partial byte is discarded with no strobe, and the next ssN-low window starts again with a command byte.
- R7: In four-wire mode misoOe is high while ssN is low and low while ssN is high, and mosiOe stays low.
- R8: A write command with code 0x7E (command byte 0x7E) switches the port to three-wire mode, which holds until reset. A read command with code 0x7E (byte 0xFE) leaves the mode unchanged.
- R9: In three-wire mode misoOe stays low and mosiOe is high only during the data phase of a read command. The read data is then driven on mosiOut.
- R10: SCLK edges while ssN is high have no effect: no strobes and no change to framing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the SCLK rate |
| rstN | input | 1 | Active-low asynchronous reset |
| ssN | input | 1 | Slave select from the master, active low |
| sclk | input | 1 | Serial clock from the master (mode 0) |
| mosiIn | input | 1 | Received value of the MOSI pad (shared line in three-wire mode) |
| mosiOut | output | 1 | Value driven onto the MOSI pad in three-wire mode |
| mosiOe | output | 1 | Output enable of the MOSI pad |
| misoOut | output | 1 | Value driven onto the MISO pad |
| misoOe | output | 1 | Output enable of the MISO pad |
| rdData | input | DATA_W | Register read data, sampled while rdTake is high |
| rdTake | output | 1 | Pulse: rdData is loaded for transmission this cycle |
| cmdValid | output | 1 | Pulse: a command byte has been received |
| cmdRead | output | 1 | Read flag of the current command |
| cmdCode | output | DATA_W-1 | Register or command code of the current command |
| dataValid | output | 1 | Pulse: a write data byte is on dataByte |
| dataByte | output | DATA_W | Received write data byte |
| xferEnd | output | 1 | Pulse: the transaction of a received command has closed |
| threeWire | output | 1 | High once the shared-line mode is active |

## Verification
The bench builds the port with its default parameters: 8-bit bytes, two synchronizer stages and 0x7E as the mode-switch code. It runs SCLK at a half period of six system cycles, so every SCLK edge clears the synchronizer latency with margin. At these values the bench can run the whole mode sequence in one run. Four-wire writes and reads come first, then aborted bytes in both the command and the data phase, and clocking with select high. A read of the switch code follows, which must not switch. The write of that code then switches to the shared line, and three-wire reads and writes and a reset back to four-wire mode close the run.

// File: rtl/spiCmdPkg.sv
package spiCmdPkg;

  // Strobes from the control to the datapath, one cycle wide each.
  typedef struct packed {
    logic sampleBit;  // shift the synchronized data input into the receive register
    logic shiftTx;    // advance the transmit register by one bit
    logic loadTx;     // load the transmit register from the register read port
  } dpCtrl_t;

  // Index of each pin inside the synchronizer bundle.
  localparam int SYNC_SCLK = 0;
  localparam int SYNC_SS   = 1;
  localparam int SYNC_MOSI = 2;
  localparam int SYNC_N    = 3;

endpackage

// File: rtl/spiCmdDatapath.sv
module spiCmdDatapath
  import spiCmdPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkPin,
  input  logic              ssNPin,
  input  logic              mosiPin,
  input  dpCtrl_t           ctrl,
  input  logic [DATA_W-1:0] rdData,
  output logic              sclkRise,
  output logic              sclkFall,
  output logic              ssActive,
  output logic              ssRise,
  output logic              ssFall,
  output logic [DATA_W-1:0] rxByteNext,
  output logic              txMsb
);

  // Idle levels: SCLK low, select high, data low.
  localparam logic [SYNC_N-1:0] IDLE_VEC = SYNC_N'(1) << SYNC_SS;

  logic [SYNC_N-1:0] rawIn;
  logic [SYNC_N-1:0] syncQ [SYNC_STAGES];
  logic [SYNC_N-1:0] syncOut;
  logic              sclkPrev, ssPrev;
  logic [DATA_W-1:0] rxShift, txShift;

  assign rawIn[SYNC_SCLK] = sclkPin;
  assign rawIn[SYNC_SS]   = ssNPin;
  assign rawIn[SYNC_MOSI] = mosiPin;

  for (genvar st = 0; st < SYNC_STAGES; st++) begin : g_sync
    if (st == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[st] <= IDLE_VEC;
        else       syncQ[st] <= rawIn;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[st] <= IDLE_VEC;
        else       syncQ[st] <= syncQ[st-1];
    end
  end

  assign syncOut = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclkPrev <= 1'b0;
      ssPrev   <= 1'b1;
    end else begin
      sclkPrev <= syncOut[SYNC_SCLK];
      ssPrev   <= syncOut[SYNC_SS];
    end

  assign sclkRise = syncOut[SYNC_SCLK] & ~sclkPrev;
  assign sclkFall = ~syncOut[SYNC_SCLK] & sclkPrev;
  assign ssActive = ~syncOut[SYNC_SS];
  assign ssRise   = syncOut[SYNC_SS] & ~ssPrev;
  assign ssFall   = ~syncOut[SYNC_SS] & ssPrev;

  assign rxByteNext = {rxShift[DATA_W-2:0], syncOut[SYNC_MOSI]};
  assign txMsb      = txShift[DATA_W-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
    end else begin
      if (ctrl.sampleBit) rxShift <= rxByteNext;
      if (ctrl.loadTx)       txShift <= rdData;
      else if (ctrl.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b0};
    end

endmodule

// File: rtl/spiCmdControl.sv
module spiCmdControl
  import spiCmdPkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int unsigned SET3W_CODE = 'h7E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkRise,
  input  logic              sclkFall,
  input  logic              ssActive,
  input  logic              ssRise,
  input  logic              ssFall,
  input  logic [DATA_W-1:0] rxByteNext,
  input  logic              txMsb,
  output dpCtrl_t           ctrl,
  output logic              cmdValid,
  output logic              cmdRead,
  output logic [DATA_W-2:0] cmdCode,
  output logic              dataValid,
  output logic [DATA_W-1:0] dataByte,
  output logic              xferEnd,
  output logic              threeWire,
  output logic              misoOe,
  output logic              mosiOe,
  output logic              txBit
);

  localparam int                CNT_W   = $clog2(DATA_W);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [DATA_W-2:0] SET3W_L  = SET3W_CODE[DATA_W-2:0];

  logic [CNT_W-1:0]  bitCnt;
  logic              inData;
  logic [DATA_W-1:0] cmdReg;
  logic              byteDone, readPhase;

  assign byteDone  = sclkRise & ssActive & (bitCnt == LAST_BIT);
  assign readPhase = inData & cmdReg[DATA_W-1];

  always_comb begin
    ctrl.sampleBit = sclkRise & ssActive;
    ctrl.shiftTx   = sclkFall & ssActive & (bitCnt != '0);
    ctrl.loadTx    = byteDone & (inData ? cmdReg[DATA_W-1] : rxByteNext[DATA_W-1]);
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      bitCnt    <= '0;
      inData    <= 1'b0;
      cmdReg    <= '0;
      cmdValid  <= 1'b0;
      dataValid <= 1'b0;
      dataByte  <= '0;
      xferEnd   <= 1'b0;
      threeWire <= 1'b0;
    end else begin
      cmdValid  <= 1'b0;
      dataValid <= 1'b0;
      xferEnd   <= ssRise & inData;
      if (ssFall || !ssActive) begin
        bitCnt <= '0;
        inData <= 1'b0;
      end else if (ctrl.sampleBit) begin
        bitCnt <= byteDone ? '0 : bitCnt + 1'b1;
        if (byteDone) begin
          if (!inData) begin
            cmdReg   <= rxByteNext;
            cmdValid <= 1'b1;
            inData   <= 1'b1;
            if (!rxByteNext[DATA_W-1] && rxByteNext[DATA_W-2:0] == SET3W_L)
              threeWire <= 1'b1;
          end else if (!cmdReg[DATA_W-1]) begin
            dataValid <= 1'b1;
            dataByte  <= rxByteNext;
          end
        end
      end
    end

  assign cmdRead = cmdReg[DATA_W-1];
  assign cmdCode = cmdReg[DATA_W-2:0];
  assign misoOe  = ssActive & ~threeWire;
  assign mosiOe  = ssActive & threeWire & readPhase;
  assign txBit   = txMsb & readPhase;

endmodule

// File: rtl/spiCmdPort.sv
module spiCmdPort
  import spiCmdPkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned SET3W_CODE  = 'h7E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ssN,
  input  logic              sclk,
  input  logic              mosiIn,
  output logic              mosiOut,
  output logic              mosiOe,
  output logic              misoOut,
  output logic              misoOe,
  input  logic [DATA_W-1:0] rdData,
  output logic              rdTake,
  output logic              cmdValid,
  output logic              cmdRead,
  output logic [DATA_W-2:0] cmdCode,
  output logic              dataValid,
  output logic [DATA_W-1:0] dataByte,
  output logic              xferEnd,
  output logic              threeWire
);

  dpCtrl_t           ctrl;
  logic              sclkRise, sclkFall, ssActive, ssRise, ssFall, txMsb, txBit;
  logic [DATA_W-1:0] rxByteNext;

  spiCmdDatapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .sclkPin(sclk), .ssNPin(ssN), .mosiPin(mosiIn),
    .ctrl(ctrl), .rdData(rdData), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .ssActive(ssActive), .ssRise(ssRise), .ssFall(ssFall),
    .rxByteNext(rxByteNext), .txMsb(txMsb)
  );

  spiCmdControl #(.DATA_W(DATA_W), .SET3W_CODE(SET3W_CODE)) i_ctl (
    .clk(clk), .rstN(rstN), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .ssActive(ssActive), .ssRise(ssRise), .ssFall(ssFall),
    .rxByteNext(rxByteNext), .txMsb(txMsb), .ctrl(ctrl),
    .cmdValid(cmdValid), .cmdRead(cmdRead), .cmdCode(cmdCode),
    .dataValid(dataValid), .dataByte(dataByte), .xferEnd(xferEnd),
    .threeWire(threeWire), .misoOe(misoOe), .mosiOe(mosiOe), .txBit(txBit)
  );

  assign rdTake  = ctrl.loadTx;
  assign misoOut = txBit;
  assign mosiOut = txBit;

endmodule

// File: rtl/spiCmdChecker.sv
module spiCmdChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ssN,
  input logic              mosiOe,
  input logic              misoOe,
  input logic              rdTake,
  input logic              cmdValid,
  input logic              cmdRead,
  input logic              dataValid,
  input logic              xferEnd,
  input logic              threeWire
);

  logic [2:0] ssHighCnt;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)          ssHighCnt <= '0;
    else if (!ssN)      ssHighCnt <= '0;
    else if (ssHighCnt != 3'd7) ssHighCnt <= ssHighCnt + 3'd1;

  assert_oe_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(mosiOe && misoOe));

  assert_mode_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    threeWire |=> threeWire);

  assert_cmd_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && dataValid));

  assert_take_in_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdTake |=> cmdRead);

  assert_end_after_select_R5: assert property (@(posedge clk) disable iff (!rstN)
    xferEnd |-> ssN);

  assert_quiet_when_deselected_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ssHighCnt >= 3'd5) |-> (!cmdValid && !dataValid && !mosiOe && !misoOe && !rdTake));

endmodule

bind spiCmdPort spiCmdChecker #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .ssN(ssN), .mosiOe(mosiOe), .misoOe(misoOe),
  .rdTake(rdTake), .cmdValid(cmdValid), .cmdRead(cmdRead),
  .dataValid(dataValid), .xferEnd(xferEnd), .threeWire(threeWire)
);

// File: tb/test_spiCmdPort.sv
module test_spiCmdPort;

  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ssN = 1'b1;
  logic       sclk = 1'b0;
  logic       masterDrive = 1'b0;
  logic [7:0] rdData = '0;
  logic       mosiOut, mosiOe, misoOut, misoOe, rdTake;
  logic       cmdValid, cmdRead, dataValid, xferEnd, threeWire;
  logic [6:0] cmdCode;
  logic [7:0] dataByte;
  logic       mosiPad;

  assign mosiPad = mosiOe ? mosiOut : masterDrive;

  always #2.5 clk = ~clk;

  spiCmdPort i_spiCmdPort (
    .clk(clk), .rstN(rstN), .ssN(ssN), .sclk(sclk), .mosiIn(mosiPad),
    .mosiOut(mosiOut), .mosiOe(mosiOe), .misoOut(misoOut), .misoOe(misoOe),
    .rdData(rdData), .rdTake(rdTake), .cmdValid(cmdValid), .cmdRead(cmdRead),
    .cmdCode(cmdCode), .dataValid(dataValid), .dataByte(dataByte),
    .xferEnd(xferEnd), .threeWire(threeWire)
  );

  int compared = 0;
  int mismatched = 0;

  // Reference model state: expected strobe streams and mode.
  logic [7:0] expCmdQ[$];
  logic [7:0] expDataQ[$];
  int         expEnds = 0;
  int         rdTakeCnt = 0;
  bit         expThree = 1'b0;

  logic [7:0] txBuf [0:7];
  logic [7:0] rdBuf [0:7];
  logic [7:0] capBuf [0:7];

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Compared on every clock: any strobe must match the head of the model's stream.
  always @(negedge clk) begin
    if (rstN) begin
      if (rdTake) rdTakeCnt++;
      if (cmdValid) begin
        if (expCmdQ.size() == 0) check(1'b0, "R2 unexpected command", {cmdRead, cmdCode}, 0);
        else begin
          logic [7:0] e;
          e = expCmdQ.pop_front();
          check({cmdRead, cmdCode} == e, "R2 command byte", {cmdRead, cmdCode}, e);
        end
      end
      if (dataValid) begin
        if (expDataQ.size() == 0) check(1'b0, "R3 R6 unexpected data strobe", dataByte, 0);
        else begin
          logic [7:0] e;
          e = expDataQ.pop_front();
          check(dataByte == e, "R3 data byte", dataByte, e);
        end
      end
      if (xferEnd) begin
        if (expEnds == 0) check(1'b0, "R5 unexpected end strobe", 1, 0);
        else expEnds--;
      end
    end
  end

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    expCmdQ.delete();
    expDataQ.delete();
    expEnds = 0;
    expThree = 1'b0;
    waitCycles(4);
    rstN = 1'b1;
    waitCycles(4);
  endtask

  // One transaction; cutBits > 0 truncates the last byte to that many bits.
  task automatic runXfer(input int nBytes, input int cutBits, input bit isRead);
    ssN = 1'b0;
    waitCycles(HALF);
    for (int b = 0; b < nBytes; b++) begin
      int nb;
      logic [7:0] cap;
      nb = (b == nBytes - 1 && cutBits > 0) ? cutBits : 8;
      rdData = rdBuf[b];
      cap = '0;
      for (int i = 0; i < nb; i++) begin
        masterDrive = txBuf[b][7-i];
        waitCycles(HALF);
        if (i == 0) begin
          if (!expThree) begin
            check(misoOe && !mosiOe, "R7 four-wire enables while selected", {misoOe, mosiOe}, 2'b10);
          end else begin
            check(!misoOe && (mosiOe == (isRead && b > 0)), "R9 three-wire enables",
                  {misoOe, mosiOe}, {1'b0, isRead && b > 0});
          end
        end
        cap = {cap[6:0], expThree ? mosiPad : misoOut};
        sclk = 1'b1;
        waitCycles(HALF);
        sclk = 1'b0;
      end
      capBuf[b] = cap;
    end
    masterDrive = 1'b0;
    waitCycles(HALF);
    ssN = 1'b1;
    waitCycles(12);
    check(!misoOe && !mosiOe, "R7 enables off after deselect", {misoOe, mosiOe}, 0);
    check(expCmdQ.size() == 0 && expDataQ.size() == 0 && expEnds == 0,
          "R2 R3 R5 R6 model streams drained", expCmdQ.size() + expDataQ.size() + expEnds, 0);
    check(threeWire == expThree, "R8 mode", threeWire, expThree);
  endtask

  task automatic checkReadBytes(input int nBytes, input string req);
    for (int b = 1; b < nBytes; b++)
      check(capBuf[b] == rdBuf[b-1], req, capBuf[b], rdBuf[b-1]);
  endtask

  initial begin
    waitCycles(3);
    // R1: state during and right after reset
    check(!misoOe && !mosiOe && !threeWire, "R1 reset outputs", {misoOe, mosiOe, threeWire}, 0);
    doReset();
    check(!cmdValid && !dataValid && !xferEnd && !rdTake && !threeWire && !misoOe && !mosiOe,
          "R1 idle after reset", {cmdValid, dataValid, xferEnd, rdTake, threeWire}, 0);

    // R2 R3 R5: four-wire write with two data bytes
    txBuf[0] = 8'h15; txBuf[1] = 8'hA5; txBuf[2] = 8'h3C;
    expCmdQ.push_back(8'h15); expDataQ.push_back(8'hA5); expDataQ.push_back(8'h3C); expEnds = 1;
    runXfer(3, 0, 1'b0);

    // R4: four-wire read of three bytes, no data strobes
    txBuf[0] = 8'hA2; txBuf[1] = 8'h00; txBuf[2] = 8'hFF; txBuf[3] = 8'h5A;
    rdBuf[0] = 8'hC3; rdBuf[1] = 8'h5A; rdBuf[2] = 8'h96; rdBuf[3] = 8'h11;
    expCmdQ.push_back(8'hA2); expEnds = 1; rdTakeCnt = 0;
    runXfer(4, 0, 1'b1);
    checkReadBytes(4, "R4 four-wire read data");
    check(rdTakeCnt == 4, "R4 read-port loads", rdTakeCnt, 4);

    // R10: clocking with select high
    for (int i = 0; i < 8; i++) begin
      masterDrive = i[0];
      waitCycles(HALF); sclk = 1'b1; waitCycles(HALF); sclk = 1'b0;
    end
    waitCycles(8);
    check(!misoOe && !mosiOe, "R10 no response while deselected", {misoOe, mosiOe}, 0);

    // R6 R5: abort in the data phase; command seen, partial byte dropped
    txBuf[0] = 8'h11; txBuf[1] = 8'hF0;
    expCmdQ.push_back(8'h11); expEnds = 1;
    runXfer(2, 4, 1'b0);
    // R6: abort inside the command byte; nothing at all
    txBuf[0] = 8'h2B;
    runXfer(1, 5, 1'b0);
    // R6: framing restarts with a command byte
    txBuf[0] = 8'h05; txBuf[1] = 8'h77;
    expCmdQ.push_back(8'h05); expDataQ.push_back(8'h77); expEnds = 1;
    runXfer(2, 0, 1'b0);

    // R8: read with the switch code leaves four-wire mode in place
    txBuf[0] = 8'hFE; txBuf[1] = 8'h00; rdBuf[0] = 8'h3E; rdBuf[1] = 8'h00;
    expCmdQ.push_back(8'hFE); expEnds = 1;
    runXfer(2, 0, 1'b1);
    checkReadBytes(2, "R4 R8 read of switch code");

    // R8: write with the switch code enters three-wire mode
    txBuf[0] = 8'h7E;
    expCmdQ.push_back(8'h7E); expEnds = 1;
    ssN = 1'b0; waitCycles(HALF);
    for (int i = 0; i < 8; i++) begin
      masterDrive = txBuf[0][7-i];
      waitCycles(HALF); sclk = 1'b1; waitCycles(HALF); sclk = 1'b0;
    end
    waitCycles(HALF);
    check(threeWire == 1'b1, "R8 switch after command byte", threeWire, 1);
    check(!misoOe && !mosiOe, "R9 no drive after switch", {misoOe, mosiOe}, 0);
    expThree = 1'b1;
    ssN = 1'b1; waitCycles(12);
    check(expEnds == 0 && expCmdQ.size() == 0, "R5 switch transaction closed", expEnds, 0);

    // R9: three-wire read on the shared line
    txBuf[0] = 8'h85; txBuf[1] = 8'h00; txBuf[2] = 8'h00;
    rdBuf[0] = 8'h69; rdBuf[1] = 8'hF0; rdBuf[2] = 8'h00;
    expCmdQ.push_back(8'h85); expEnds = 1;
    runXfer(3, 0, 1'b1);
    checkReadBytes(3, "R9 three-wire read data");

    // R9 R3: three-wire write, slave never drives
    txBuf[0] = 8'h06; txBuf[1] = 8'h42;
    expCmdQ.push_back(8'h06); expDataQ.push_back(8'h42); expEnds = 1;
    runXfer(2, 0, 1'b0);

    // R1 R8: reset returns to four-wire mode
    doReset();
    check(threeWire == 1'b0, "R1 R8 reset to four-wire", threeWire, 0);
    txBuf[0] = 8'h09; txBuf[1] = 8'h81;
    expCmdQ.push_back(8'h09); expDataQ.push_back(8'h81); expEnds = 1;
    runXfer(2, 0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    waitCycles(150000);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule